// File: doc/BRIEF.md
# Multiword Add/Subtract Carry Unit

This block performs one word-sized step of an extended-precision addition or subtraction. Each step takes two operands, X and Y, and a carry-in held in a dedicated status word. The status word is the hardware image of the carry/overflow register that software sees. The step produces the word-sized result and rewrites the status word with the new carry and signed overflow. Software chains steps across many words by feeding the least significant words first and moving towards the most significant.

Subtraction is formed as X plus the one's complement of Y plus the stored carry. A multiword subtract therefore starts with the carry set to one, and a multiword add starts with it cleared. Software presets the carry by writing the whole status word. After any step, only the two low status bits can be non-zero. The overflow bit is meaningful after the last step of a chain, where it reports signed overflow of the full multiword operation.

Top module: `mwc_unit`

## Requirements
- R1: After reset `res_data` is 0, `stat_word` is 0 and `res_valid` is 0.
- R2: A step with `step_op`=0 (add) loads `res_data` with (X + Y + carry-in) mod 2^W on the next clock edge. The carry-in is `stat_word` bit 0 before the step.
- R3: A step with `step_op`=1 (subtract) loads `res_data` with (X + ~Y + carry-in) mod 2^W on the next clock edge.
- R4: A step writes the carry out of the most significant result bit to `stat_word` bit 0. `carry_flag` mirrors that bit.
- R5: A step writes signed two's-complement overflow of the word operation to `stat_word` bit 1. This is carry into the MSB XOR carry out of the MSB. `ovf_flag` mirrors that bit.
- R6: After every step, `stat_word` bits W-1 down to 2 are zero.
- R7: When `stat_wr_en` is high and `step_en` is low, `stat_word` takes `stat_wr_data` on the next edge. `res_data` is unchanged.
- R8: When `stat_wr_en` and `step_en` are high in the same cycle, the step uses the old carry and writes the status. The write has no effect.
- R9: `res_valid` is high for exactly the cycle after each step. In cycles with neither a step nor a status write, `res_data` and `stat_word` hold their values.
- R10: Two chained steps give the correct 2W-bit sum and difference. The final overflow bit equals the signed overflow of the 2W-bit operation. This holds for an add chain started with carry 0 and a subtract chain started with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Perform one extended step this cycle |
| step_op | input | 1 | 0 = add, 1 = subtract |
| opnd_x | input | W | First operand word (X) |
| opnd_y | input | W | Second operand word (Y) |
| stat_wr_en | input | 1 | Write the status word |
| stat_wr_data | input | W | Value for a status write |
| res_data | output | W | Result word of the last step |
| res_valid | output | 1 | High for the cycle after a step |
| stat_word | output | W | Status word: bit 0 carry, bit 1 overflow |
| carry_flag | output | 1 | Status bit 0 |
| ovf_flag | output | 1 | Status bit 1 |

## Verification
The hardest case is a chain whose carry-in comes from a status word that held junk in its upper bits. Another hard case is a status write that collides with a step. The bench reaches both directly. It writes a status value with all upper bits set, then issues a step and checks that the upper bits clear. It also drives a write and a step in the same cycle with opposite carry values. Two-word chains cover the overflow boundaries at the most negative and most positive 2W-bit values. These chains run alongside random single steps, all checked against a behavioural model every clock.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
    localparam int CARRY_BIT = 0;
    localparam int OVF_BIT   = 1;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } mwc_op_e;
endpackage

// File: rtl/mwc_operand_prep.sv
module mwc_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] y_in,
    input  logic         do_sub,
    output logic [W-1:0] y_out
);
    // Subtract uses the one's complement of Y; the +1 comes from the stored carry.
    always_comb begin
        y_out = do_sub ? ~y_in : y_in;
    end
endmodule

// File: rtl/mwc_add_core.sv
module mwc_add_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0]   full_sum;
    logic [W-2:0] low_sum_unused;
    logic         carry_into_msb;

    always_comb begin
        full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum      = full_sum[W-1:0];
        cout     = full_sum[W];
        // Carry into the top bit is recovered from the top bit's own sum.
        carry_into_msb = a[W-1] ^ b[W-1] ^ full_sum[W-1];
        ovf      = carry_into_msb ^ full_sum[W];
        low_sum_unused = full_sum[W-2:0];
    end
endmodule

// File: rtl/mwc_unit.sv
module mwc_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         step_op,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    input  logic         stat_wr_en,
    input  logic [W-1:0] stat_wr_data,
    output logic [W-1:0] res_data,
    output logic         res_valid,
    output logic [W-1:0] stat_word,
    output logic         carry_flag,
    output logic         ovf_flag
);
    import mwc_pkg::*;

    localparam int FLAG_BITS = 2;

    typedef struct packed {
        logic [W-1:0] result;
        logic [W-1:0] status;
        logic         valid;
    } state_t;

    state_t state_d, state_q;

    mwc_op_e      op_sel;
    logic [W-1:0] y_eff;
    logic [W-1:0] core_sum;
    logic         core_cout;
    logic         core_ovf;

    assign op_sel = mwc_op_e'(step_op);

    mwc_operand_prep #(.W(W)) u_prep (
        .y_in   (opnd_y),
        .do_sub (op_sel == OP_SUB),
        .y_out  (y_eff)
    );

    mwc_add_core #(.W(W)) u_core (
        .a    (opnd_x),
        .b    (y_eff),
        .cin  (state_q.status[CARRY_BIT]),
        .sum  (core_sum),
        .cout (core_cout),
        .ovf  (core_ovf)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = step_en;
        if (step_en) begin
            state_d.result             = core_sum;
            state_d.status             = '0;
            state_d.status[CARRY_BIT]  = core_cout;
            state_d.status[OVF_BIT]    = core_ovf;
        end else if (stat_wr_en) begin
            state_d.status = stat_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_data   = state_q.result;
    assign res_valid  = state_q.valid;
    assign stat_word  = state_q.status;
    assign carry_flag = state_q.status[CARRY_BIT];
    assign ovf_flag   = state_q.status[OVF_BIT];

    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (stat_word[W-1:FLAG_BITS] == '0)); // R6

    AST_OVF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (ovf_flag ==
            (($past(opnd_x[W-1]) == ($past(opnd_y[W-1]) ^ $past(step_op)))
             && (res_data[W-1] != $past(opnd_x[W-1]))))); // R5

    AST_STAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && !step_en) |=> (stat_word == $past(stat_wr_data))); // R7

    AST_WRITE_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && !step_en) |=> $stable(res_data)); // R7

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> res_valid); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !stat_wr_en) |=> ($stable(stat_word) && $stable(res_data) && !res_valid)); // R9
endmodule

// File: tb/mwc_unit_bench.sv
module mwc_unit_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0;
    logic         step_op = 1'b0;
    logic [W-1:0] opnd_x = '0;
    logic [W-1:0] opnd_y = '0;
    logic         stat_wr_en = 1'b0;
    logic [W-1:0] stat_wr_data = '0;
    logic [W-1:0] res_data;
    logic         res_valid;
    logic [W-1:0] stat_word;
    logic         carry_flag;
    logic         ovf_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural model state
    logic [W-1:0] m_res = '0;
    logic [W-1:0] m_stat = '0;
    logic         m_valid = 1'b0;

    always #5 clk = ~clk;

    mwc_unit #(.W(W)) u_mwc_unit (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_op(step_op),
        .opnd_x(opnd_x), .opnd_y(opnd_y), .stat_wr_en(stat_wr_en),
        .stat_wr_data(stat_wr_data), .res_data(res_data), .res_valid(res_valid),
        .stat_word(stat_word), .carry_flag(carry_flag), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of one clock edge, written from the requirements.
    task automatic model_edge();
        longint unsigned s;
        logic [W-1:0] yv;
        if (step_en) begin
            yv = step_op ? ~opnd_y : opnd_y;
            s = longint'(opnd_x) + longint'(yv) + longint'(m_stat[0]);
            m_res = s[W-1:0];
            m_stat = '0;
            m_stat[0] = s[W];
            m_stat[1] = (opnd_x[W-1] == yv[W-1]) && (s[W-1] != opnd_x[W-1]);
        end else if (stat_wr_en) begin
            m_stat = stat_wr_data;
        end
        m_valid = step_en;
    endtask

    task automatic compare_all(input string req);
        check({req, " res_data"}, 64'(res_data), 64'(m_res));
        check({req, " stat_word"}, 64'(stat_word), 64'(m_stat));
        check({req, " res_valid"}, 64'(res_valid), 64'(m_valid));
        check({req, " carry_flag"}, 64'(carry_flag), 64'(m_stat[0]));
        check({req, " ovf_flag"}, 64'(ovf_flag), 64'(m_stat[1]));
    endtask

    // Drive inputs after a falling edge, model the rising edge, compare at the next falling edge.
    task automatic cyc(input string req, input logic st, input logic op,
                       input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic wr, input logic [W-1:0] wd);
        step_en = st; step_op = op; opnd_x = x; opnd_y = y;
        stat_wr_en = wr; stat_wr_data = wd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic chain2(input string req, input logic op,
                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp64;
        logic [63:0] got;
        logic        exp_ovf;
        cyc(req, 1'b0, 1'b0, '0, '0, 1'b1, op ? 32'h1 : 32'h0);
        cyc(req, 1'b1, op, a[31:0], b[31:0], 1'b0, '0);
        got[31:0] = res_data;
        cyc(req, 1'b1, op, a[63:32], b[63:32], 1'b0, '0);
        got[63:32] = res_data;
        exp64 = op ? (a - b) : (a + b);
        exp_ovf = op ? ((a[63] != b[63]) && (exp64[63] != a[63]))
                     : ((a[63] == b[63]) && (exp64[63] != a[63]));
        check({req, " chained value"}, got, exp64);
        check({req, " chained overflow"}, 64'(ovf_flag), 64'(exp_ovf));
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<200000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [W-1:0] rx;
        logic [W-1:0] ry;
        repeat (3) @(negedge clk);
        compare_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after release");

        // R2 adds without and with carry-in
        cyc("R2", 1'b1, 1'b0, 32'd5, 32'd7, 1'b0, '0);
        cyc("R2", 1'b0, 1'b0, '0, '0, 1'b1, 32'h1);
        cyc("R2 cin", 1'b1, 1'b0, 32'd100, 32'd23, 1'b0, '0);
        // R4 carry out of top bit
        cyc("R4", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h1, 1'b0, '0);
        cyc("R4 carry used", 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, '0);
        // R3 subtract with carry set and clear
        cyc("R3", 1'b0, 1'b0, '0, '0, 1'b1, 32'h1);
        cyc("R3", 1'b1, 1'b1, 32'd10, 32'd3, 1'b0, '0);
        cyc("R3 borrow", 1'b1, 1'b1, 32'd3, 32'd10, 1'b0, '0);
        // R5 overflow boundaries
        cyc("R5 add", 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h1, 1'b0, '0);
        cyc("R5", 1'b0, 1'b0, '0, '0, 1'b1, 32'h1);
        cyc("R5 sub", 1'b1, 1'b1, 32'h8000_0000, 32'h1, 1'b0, '0);
        // R6 junk upper bits cleared by a step
        cyc("R7 write", 1'b0, 1'b0, '0, '0, 1'b1, 32'hFFFF_FFFC);
        cyc("R6", 1'b1, 1'b0, 32'h1234, 32'h1, 1'b0, '0);
        // R8 collision: write ignored
        cyc("R8", 1'b0, 1'b0, '0, '0, 1'b1, 32'h0);
        cyc("R8 collide", 1'b1, 1'b0, 32'h10, 32'h20, 1'b1, 32'hFFFF_FFFF);
        // R9 idle hold
        cyc("R9 idle", 1'b0, 1'b1, 32'hDEAD, 32'hBEEF, 1'b0, '0);
        cyc("R9 idle", 1'b0, 1'b0, 32'h1, 32'h2, 1'b0, '0);
        // R10 chains
        chain2("R10 add", 1'b0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001);
        chain2("R10 add ovf", 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
        chain2("R10 sub", 1'b1, 64'h0000_0002_0000_0000, 64'h1);
        chain2("R10 sub ovf", 1'b1, 64'h8000_0000_0000_0000, 64'h1);
        chain2("R10 sub neg", 1'b1, 64'h5, 64'h9);
        // Random mix
        for (int i = 0; i < 300; i++) begin
            rx = $urandom;
            ry = $urandom;
            case ($urandom_range(0, 3))
                0: cyc("R2 rand", 1'b1, 1'b0, rx, ry, 1'b0, '0);
                1: cyc("R3 rand", 1'b1, 1'b1, rx, ry, 1'b0, '0);
                2: cyc("R7 rand", 1'b0, 1'b0, rx, ry, 1'b1, ry);
                default: cyc("R9 rand", 1'b0, 1'b0, rx, ry, 1'b0, '0);
            endcase
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule